// File: doc/BRIEF.md
# Virtual Memory Map Initialization Sequencer

This block brings a paged virtual memory system out of cold start. On leaving reset it samples three static configuration inputs: a two-bit virtual-size selector, a mask of which storage modules are fitted, and a two-bit code for the capacity of the storage chips. From these it works out how many 64K-word banks the virtual space has, how many pages each module holds and how many real pages exist in total. If no module is fitted it stops at once and raises a no-storage error.

With storage present it makes three passes over the map. The first pass writes every map entry as an identity mapping. The second pass flushes every cache line of each page and then marks the entry vacant. The third pass walks the modules from the lowest index upward. It packs the pages of the fitted modules into consecutive virtual pages starting at page zero and zeroes each page with word stores just after mapping it. Pages that get no real storage keep their vacant entry. The block then pulses a fault-clear strobe, loads the run-time control value and holds done.

The map RAM, the cache and the storage sit outside the block. The block drives three request ports. The map write port has a busy input, and the block issues no request of any kind while busy is high.

Top module: `vmap_init`

## Requirements
- R1: `virtBanks` reports 1024 when `sizeSel[1]` is 1, 256 when `sizeSel` is 2'b01 and 64 when it is 2'b00. The virtual page count is `virtBanks` times 2^BANK_PG_W.
- R2: Pages per module is 2^(MODPG_BASE_W + 2*`chipSize`), which is 256*4^n at the defaults. `realPages` equals that value times the number of ones in `modMask`.
- R3: When `modMask` is zero, `noStorage` goes high and stays high. No map write, flush or store is ever issued, `done` stays low and `realPages` reads 0.
- R4: Pass 1 writes every virtual page in ascending order with real page = virtual page mod 2^RP_W and with dirty and write-protect both 0. It completes before the first flush.
- R5: Pass 2 runs page by page. For each page it issues 2^(OFS_W-LINE_W) flushes, whose addresses are {page, line, LINE_W zero bits} with line ascending from 0. It then rewrites that page's entry as vacant: dirty=1, write-protect=1, real page 0.
- R6: Pass 3 starts after the last vacant write. It takes the modules in ascending index order. For each fitted module it maps the module's real pages in ascending order onto consecutive virtual pages from 0, with both flags 0. Module m's pages start at real page m times the pages per module.
- R7: Right after each pass-3 map write, and before the next map write, the block issues 2^OFS_W stores of zero to {page, offset} with the offset ascending from 0.
- R8: Pass 3 stops after the last module or when the virtual space runs out, whichever comes first. Every virtual page not mapped by pass 3 ends vacant.
- R9: Completion waits for the map port to be idle. `faultClear` pulses once, then `ctrlLoad` pulses once in the next cycle with `ctrlValue` = 2'b01 (bit 0 fault reporting on, bit 1 single-error reporting off). After that `done` stays high.
- R10: `mapWrite`, `flushReq` and `storeReq` are never high while `mapBusy` is high, and at most one of them is high in any cycle.
- R11: While `rst` is high and in the cycle after it, every request output, `done`, `noStorage`, `faultClear` and `ctrlLoad` are low, and `virtBanks` and `realPages` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; the sequence starts when it falls |
| sizeSel | input | 2 | Virtual size select (see R1) |
| modMask | input | NUM_MOD (4) | Bit m set means storage module m is fitted |
| chipSize | input | 2 | Storage chip capacity code n |
| mapBusy | input | 1 | Map port busy; no request may issue while high |
| mapWrite | output | 1 | Map entry write strobe |
| mapVpage | output | VP_W (18) | Virtual page of the map write |
| mapRpage | output | RP_W (16) | Real page of the map write |
| mapDirty | output | 1 | Dirty flag of the map write |
| mapWp | output | 1 | Write-protect flag of the map write |
| flushReq | output | 1 | Cache line flush request |
| flushAddr | output | VP_W+OFS_W (26) | Virtual word address of the flushed line |
| storeReq | output | 1 | Word store request |
| storeAddr | output | VP_W+OFS_W (26) | Virtual word address of the store |
| storeData | output | WORD_W (16) | Store data (zero) |
| faultClear | output | 1 | One-cycle fault clear pulse |
| ctrlLoad | output | 1 | One-cycle control register load strobe |
| ctrlValue | output | 2 | Control value loaded with ctrlLoad |
| done | output | 1 | Initialization complete |
| noStorage | output | 1 | No storage module fitted |
| virtBanks | output | 11 | Virtual size in 64K-word banks |
| realPages | output | TOT_W (17) | Total real pages |

## Verification
The bench checks compaction with gaps in the module mask. If absent modules did not advance the real page, or if a virtual page were spent on them, the final map would show shifted real pages. One case fits more real storage than the virtual space holds. A design that kept going would write past the last virtual page, and one that stopped early would leave pages vacant. The bench forces extra busy cycles in one run and checks the order of the passes on every request: identity before any flush, flushes before vacate, and stores only after all vacates and only directly behind their own page's map write. This catches a sequencer that overlaps passes or ignores busy. An empty module mask must produce no traffic at all, and selector value 2'b11 must pick the largest size.

// File: rtl/vmap_init_pkg.sv
package vmap_init_pkg;

  typedef enum logic [3:0] {
    S_CONFIG,
    S_P1_MAP,
    S_P2_FLUSH,
    S_P2_VACATE,
    S_P3_FIND,
    S_P3_MAP,
    S_P3_ZERO,
    S_FIN_CLEAR,
    S_FIN_LOAD,
    S_DONE,
    S_NOSTORE
  } vmiState_t;

  typedef enum logic [1:0] {
    MK_IDENT   = 2'd0,
    MK_VACANT  = 2'd1,
    MK_COMPACT = 2'd2
  } mapKind_t;

  // strobes from control to datapath
  typedef struct packed {
    logic     cfgLoad;
    logic     vpClear;
    logic     vpInc;
    logic     lineInc;
    logic     ofsClear;
    logic     ofsInc;
    logic     rpClear;
    logic     rpInc;
    logic     rpSkip;
    logic     modClear;
    logic     modInc;
    logic     leftLoad;
    logic     leftDec;
    mapKind_t mapKind;
  } vmiStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic vpLast;
    logic lineLast;
    logic ofsLast;
    logic modPresent;
    logic modEnd;
    logic leftLast;
    logic maskZero;
  } vmiStatus_t;

  // bit0: fault reporting on, bit1: single-error reporting off
  localparam logic [1:0] CTRL_RUN_VALUE = 2'b01;

endpackage

// File: rtl/vmap_init_dp.sv
module vmap_init_dp
  import vmap_init_pkg::*;
#(
  parameter int OFS_W        = 8,
  parameter int LINE_W       = 4,
  parameter int BANK_PG_W    = 8,
  parameter int MODPG_BASE_W = 8,
  parameter int NUM_MOD      = 4,
  parameter int RP_W         = 16,
  parameter int WORD_W       = 16,
  localparam int VP_W        = 10 + BANK_PG_W,
  localparam int VA_W        = VP_W + OFS_W,
  localparam int LINES_W     = OFS_W - LINE_W,
  localparam int PPM_W       = MODPG_BASE_W + 7,
  localparam int CNT_W       = $clog2(NUM_MOD + 1),
  localparam int TOT_W       = MODPG_BASE_W + 6 + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         sizeSel,
  input  logic [NUM_MOD-1:0] modMask,
  input  logic [1:0]         chipSize,
  input  vmiStrobe_t         stb,
  output vmiStatus_t         stat,
  output logic [VP_W-1:0]    mapVpage,
  output logic [RP_W-1:0]    mapRpage,
  output logic               mapDirty,
  output logic               mapWp,
  output logic [VA_W-1:0]    flushAddr,
  output logic [VA_W-1:0]    storeAddr,
  output logic [WORD_W-1:0]  storeData,
  output logic [10:0]        virtBanks,
  output logic [TOT_W-1:0]   realPages
);

  logic               cfgValid;
  logic [1:0]         sizeQ;
  logic [NUM_MOD-1:0] maskQ;
  logic [1:0]         chipQ;

  logic [VP_W-1:0]    vpage;
  logic [LINES_W-1:0] line;
  logic [OFS_W-1:0]   ofs;
  logic [TOT_W-1:0]   rpage;
  logic [CNT_W-1:0]   modIdx;
  logic [PPM_W-1:0]   leftCnt;

  logic [10:0]        banksRaw;
  logic [PPM_W-1:0]   ppm;
  logic [CNT_W-1:0]   modCount;
  logic [TOT_W-1:0]   totalRaw;
  logic [VP_W:0]      vpTotal;
  logic               present;

  // configuration capture
  always_ff @(posedge clk) begin
    if (rst) begin
      cfgValid <= 1'b0;
      sizeQ    <= '0;
      maskQ    <= '0;
      chipQ    <= '0;
    end else if (stb.cfgLoad) begin
      cfgValid <= 1'b1;
      sizeQ    <= sizeSel;
      maskQ    <= modMask;
      chipQ    <= chipSize;
    end
  end

  // derived sizes
  always_comb begin
    if (sizeQ[1])      banksRaw = 11'd1024;
    else if (sizeQ[0]) banksRaw = 11'd256;
    else               banksRaw = 11'd64;
  end

  always_comb begin
    int shamt;
    shamt = MODPG_BASE_W + 2 * int'(chipQ);
    ppm   = PPM_W'(1) << shamt;
  end

  always_comb begin
    modCount = '0;
    for (int m = 0; m < NUM_MOD; m++) begin
      modCount = modCount + CNT_W'(maskQ[m]);
    end
  end

  assign totalRaw  = TOT_W'(ppm) * TOT_W'(modCount);
  assign vpTotal   = (VP_W + 1)'(banksRaw) << BANK_PG_W;
  assign virtBanks = cfgValid ? banksRaw : '0;
  assign realPages = cfgValid ? totalRaw : '0;

  always_comb begin
    present = 1'b0;
    for (int m = 0; m < NUM_MOD; m++) begin
      if (modIdx == CNT_W'(m)) present = maskQ[m];
    end
  end

  // walking counters
  always_ff @(posedge clk) begin
    if (rst) begin
      vpage   <= '0;
      line    <= '0;
      ofs     <= '0;
      rpage   <= '0;
      modIdx  <= '0;
      leftCnt <= '0;
    end else begin
      if (stb.vpClear)    vpage <= '0;
      else if (stb.vpInc) vpage <= vpage + VP_W'(1);

      if (stb.lineInc) line <= line + LINES_W'(1);

      if (stb.ofsClear)    ofs <= '0;
      else if (stb.ofsInc) ofs <= ofs + OFS_W'(1);

      if (stb.rpClear)     rpage <= '0;
      else if (stb.rpInc)  rpage <= rpage + TOT_W'(1);
      else if (stb.rpSkip) rpage <= rpage + TOT_W'(ppm);

      if (stb.modClear)    modIdx <= '0;
      else if (stb.modInc) modIdx <= modIdx + CNT_W'(1);

      if (stb.leftLoad)     leftCnt <= ppm;
      else if (stb.leftDec) leftCnt <= leftCnt - PPM_W'(1);
    end
  end

  assign stat.vpLast     = ({1'b0, vpage} + (VP_W + 1)'(1)) == vpTotal;
  assign stat.lineLast   = &line;
  assign stat.ofsLast    = &ofs;
  assign stat.modEnd     = modIdx == CNT_W'(NUM_MOD);
  assign stat.modPresent = present;
  assign stat.leftLast   = leftCnt == PPM_W'(1);
  assign stat.maskZero   = modMask == '0;

  // request payloads
  assign mapVpage = vpage;
  always_comb begin
    unique case (stb.mapKind)
      MK_VACANT: begin
        mapRpage = '0;
        mapDirty = 1'b1;
        mapWp    = 1'b1;
      end
      MK_COMPACT: begin
        mapRpage = RP_W'(rpage);
        mapDirty = 1'b0;
        mapWp    = 1'b0;
      end
      default: begin
        mapRpage = RP_W'(vpage);
        mapDirty = 1'b0;
        mapWp    = 1'b0;
      end
    endcase
  end

  assign flushAddr = {vpage, line, {LINE_W{1'b0}}};
  assign storeAddr = {vpage, ofs};
  assign storeData = '0;

endmodule

// File: rtl/vmap_init_ctrl.sv
module vmap_init_ctrl
  import vmap_init_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mapBusy,
  input  vmiStatus_t stat,
  output vmiStrobe_t stb,
  output logic       mapWrite,
  output logic       flushReq,
  output logic       storeReq,
  output logic       faultClear,
  output logic       ctrlLoad,
  output logic [1:0] ctrlValue,
  output logic       done,
  output logic       noStorage
);

  vmiState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= S_CONFIG;
    else     state <= nextState;
  end

  always_comb begin
    nextState  = state;
    stb        = '0;
    mapWrite   = 1'b0;
    flushReq   = 1'b0;
    storeReq   = 1'b0;
    faultClear = 1'b0;
    ctrlLoad   = 1'b0;
    done       = 1'b0;
    noStorage  = 1'b0;

    unique case (state)
      S_CONFIG: begin
        stb.cfgLoad = 1'b1;
        stb.vpClear = 1'b1;
        nextState   = stat.maskZero ? S_NOSTORE : S_P1_MAP;
      end

      S_P1_MAP: begin
        stb.mapKind = MK_IDENT;
        if (!mapBusy) begin
          mapWrite = 1'b1;
          if (stat.vpLast) begin
            stb.vpClear = 1'b1;
            nextState   = S_P2_FLUSH;
          end else begin
            stb.vpInc = 1'b1;
          end
        end
      end

      S_P2_FLUSH: begin
        if (!mapBusy) begin
          flushReq    = 1'b1;
          stb.lineInc = 1'b1;
          if (stat.lineLast) nextState = S_P2_VACATE;
        end
      end

      S_P2_VACATE: begin
        stb.mapKind = MK_VACANT;
        if (!mapBusy) begin
          mapWrite = 1'b1;
          if (stat.vpLast) begin
            stb.vpClear  = 1'b1;
            stb.rpClear  = 1'b1;
            stb.modClear = 1'b1;
            nextState    = S_P3_FIND;
          end else begin
            stb.vpInc = 1'b1;
            nextState = S_P2_FLUSH;
          end
        end
      end

      S_P3_FIND: begin
        if (stat.modEnd) begin
          nextState = S_FIN_CLEAR;
        end else if (stat.modPresent) begin
          stb.leftLoad = 1'b1;
          nextState    = S_P3_MAP;
        end else begin
          stb.rpSkip = 1'b1;
          stb.modInc = 1'b1;
        end
      end

      S_P3_MAP: begin
        stb.mapKind = MK_COMPACT;
        if (!mapBusy) begin
          mapWrite     = 1'b1;
          stb.ofsClear = 1'b1;
          nextState    = S_P3_ZERO;
        end
      end

      S_P3_ZERO: begin
        if (!mapBusy) begin
          storeReq   = 1'b1;
          stb.ofsInc = 1'b1;
          if (stat.ofsLast) begin
            stb.rpInc   = 1'b1;
            stb.leftDec = 1'b1;
            if (stat.vpLast) begin
              nextState = S_FIN_CLEAR;
            end else begin
              stb.vpInc = 1'b1;
              if (stat.leftLast) begin
                stb.modInc = 1'b1;
                nextState  = S_P3_FIND;
              end else begin
                nextState = S_P3_MAP;
              end
            end
          end
        end
      end

      S_FIN_CLEAR: begin
        if (!mapBusy) begin
          faultClear = 1'b1;
          nextState  = S_FIN_LOAD;
        end
      end

      S_FIN_LOAD: begin
        ctrlLoad  = 1'b1;
        nextState = S_DONE;
      end

      S_DONE:    done = 1'b1;
      S_NOSTORE: noStorage = 1'b1;
      default:   nextState = S_CONFIG;
    endcase
  end

  assign ctrlValue = ctrlLoad ? CTRL_RUN_VALUE : 2'b00;

endmodule

// File: rtl/vmap_init.sv
module vmap_init
  import vmap_init_pkg::*;
#(
  parameter int OFS_W        = 8,
  parameter int LINE_W       = 4,
  parameter int BANK_PG_W    = 8,
  parameter int MODPG_BASE_W = 8,
  parameter int NUM_MOD      = 4,
  parameter int RP_W         = 16,
  parameter int WORD_W       = 16,
  localparam int VP_W        = 10 + BANK_PG_W,
  localparam int VA_W        = VP_W + OFS_W,
  localparam int CNT_W       = $clog2(NUM_MOD + 1),
  localparam int TOT_W       = MODPG_BASE_W + 6 + CNT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         sizeSel,
  input  logic [NUM_MOD-1:0] modMask,
  input  logic [1:0]         chipSize,
  input  logic               mapBusy,
  output logic               mapWrite,
  output logic [VP_W-1:0]    mapVpage,
  output logic [RP_W-1:0]    mapRpage,
  output logic               mapDirty,
  output logic               mapWp,
  output logic               flushReq,
  output logic [VA_W-1:0]    flushAddr,
  output logic               storeReq,
  output logic [VA_W-1:0]    storeAddr,
  output logic [WORD_W-1:0]  storeData,
  output logic               faultClear,
  output logic               ctrlLoad,
  output logic [1:0]         ctrlValue,
  output logic               done,
  output logic               noStorage,
  output logic [10:0]        virtBanks,
  output logic [TOT_W-1:0]   realPages
);

  vmiStrobe_t stb;
  vmiStatus_t stat;

  vmap_init_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .mapBusy    (mapBusy),
    .stat       (stat),
    .stb        (stb),
    .mapWrite   (mapWrite),
    .flushReq   (flushReq),
    .storeReq   (storeReq),
    .faultClear (faultClear),
    .ctrlLoad   (ctrlLoad),
    .ctrlValue  (ctrlValue),
    .done       (done),
    .noStorage  (noStorage)
  );

  vmap_init_dp #(
    .OFS_W        (OFS_W),
    .LINE_W       (LINE_W),
    .BANK_PG_W    (BANK_PG_W),
    .MODPG_BASE_W (MODPG_BASE_W),
    .NUM_MOD      (NUM_MOD),
    .RP_W         (RP_W),
    .WORD_W       (WORD_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .sizeSel   (sizeSel),
    .modMask   (modMask),
    .chipSize  (chipSize),
    .stb       (stb),
    .stat      (stat),
    .mapVpage  (mapVpage),
    .mapRpage  (mapRpage),
    .mapDirty  (mapDirty),
    .mapWp     (mapWp),
    .flushAddr (flushAddr),
    .storeAddr (storeAddr),
    .storeData (storeData),
    .virtBanks (virtBanks),
    .realPages (realPages)
  );

endmodule

// File: rtl/vmap_init_check.sv
module vmap_init_check #(
  parameter int RP_W = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            mapBusy,
  input logic            mapWrite,
  input logic            mapDirty,
  input logic            mapWp,
  input logic [RP_W-1:0] mapRpage,
  input logic            flushReq,
  input logic            storeReq,
  input logic            faultClear,
  input logic            ctrlLoad,
  input logic            done,
  input logic            noStorage
);

  logic anyReq;
  assign anyReq = mapWrite | flushReq | storeReq;

  assert_no_req_busy_R10: assert property (@(posedge clk) disable iff (rst)
    anyReq |-> !mapBusy);

  assert_one_req_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mapWrite, flushReq, storeReq}));

  assert_vacant_form_R5: assert property (@(posedge clk) disable iff (rst)
    (mapWrite && mapDirty) |-> (mapWp && mapRpage == '0));

  assert_nostore_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    noStorage |-> (!anyReq && !done));

  assert_nostore_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    noStorage |=> noStorage);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!anyReq && !faultClear && !ctrlLoad));

  assert_load_after_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ctrlLoad |-> $past(faultClear));

  assert_done_after_load_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(ctrlLoad));

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> !(anyReq || done || noStorage || faultClear || ctrlLoad));

endmodule

bind vmap_init vmap_init_check #(.RP_W(RP_W)) u_check (
  .clk        (clk),
  .rst        (rst),
  .mapBusy    (mapBusy),
  .mapWrite   (mapWrite),
  .mapDirty   (mapDirty),
  .mapWp      (mapWp),
  .mapRpage   (mapRpage),
  .flushReq   (flushReq),
  .storeReq   (storeReq),
  .faultClear (faultClear),
  .ctrlLoad   (ctrlLoad),
  .done       (done),
  .noStorage  (noStorage)
);

// File: tb/vmap_init_test.sv
module vmap_init_test;

  localparam int CLK_PERIOD = 10;
  localparam int OFS_W      = 4;
  localparam int LINE_W     = 2;
  localparam int BANK_PG_W  = 0;
  localparam int MODPG_B    = 1;
  localparam int VP_W       = 10 + BANK_PG_W;
  localparam int VA_W       = VP_W + OFS_W;
  localparam int TOT_W      = MODPG_B + 6 + 3;
  localparam int WORDS      = 1 << OFS_W;
  localparam int LINES      = 1 << (OFS_W - LINE_W);
  localparam int NPG        = 1 << VP_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] sizeSel = '0;
  logic [3:0] modMask = '0;
  logic [1:0] chipSize = '0;
  logic mapBusy = 1'b0;
  logic mapWrite, mapDirty, mapWp, flushReq, storeReq;
  logic [VP_W-1:0] mapVpage;
  logic [15:0] mapRpage;
  logic [VA_W-1:0] flushAddr, storeAddr;
  logic [15:0] storeData;
  logic faultClear, ctrlLoad, done, noStorage;
  logic [1:0] ctrlValue;
  logic [10:0] virtBanks;
  logic [TOT_W-1:0] realPages;

  vmap_init #(
    .OFS_W(OFS_W), .LINE_W(LINE_W), .BANK_PG_W(BANK_PG_W),
    .MODPG_BASE_W(MODPG_B), .NUM_MOD(4), .RP_W(16), .WORD_W(16)
  ) uut (
    .clk(clk), .rst(rst), .sizeSel(sizeSel), .modMask(modMask), .chipSize(chipSize),
    .mapBusy(mapBusy), .mapWrite(mapWrite), .mapVpage(mapVpage), .mapRpage(mapRpage),
    .mapDirty(mapDirty), .mapWp(mapWp), .flushReq(flushReq), .flushAddr(flushAddr),
    .storeReq(storeReq), .storeAddr(storeAddr), .storeData(storeData),
    .faultClear(faultClear), .ctrlLoad(ctrlLoad), .ctrlValue(ctrlValue), .done(done),
    .noStorage(noStorage), .virtBanks(virtBanks), .realPages(realPages)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  // map / cache / storage model
  int mRp [NPG];
  bit mD [NPG];
  bit mW [NPG];
  int wCnt [NPG];
  int fNext [NPG];
  int sNext [NPG];
  int expRp [NPG];
  int V, mapped, p1Tot, p2Tot, nextP3, fTot, sTot, reqTot, mwTot, fcCnt, clCnt;
  int vR4, vR5, vR6, vR7, vR9, vR10;
  int busyCnt = 0;
  bit stall = 1'b0;
  int cyc = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    int vp;
    int ln;
    int of;
    cyc++;
    if (busyCnt > 0) busyCnt--;
    mapBusy = rst ? 1'b0 : ((busyCnt > 0) || (stall && (cyc % 5 == 0)));
    #1;
    if (!rst) begin
      if ((mapWrite || flushReq || storeReq) && mapBusy) vR10++;
      if (int'(mapWrite) + int'(flushReq) + int'(storeReq) > 1) vR10++;
      if (mapWrite || flushReq || storeReq) reqTot++;
      if (mapWrite) begin
        vp = int'(mapVpage);
        mwTot++;
        case (wCnt[vp])
          0: begin
            if (!(int'(mapRpage) == vp % 65536 && !mapDirty && !mapWp && fTot == 0)) vR4++;
            p1Tot++;
          end
          1: begin
            if (!(mapDirty && mapWp && mapRpage == 0 && fNext[vp] == LINES)) vR5++;
            p2Tot++;
          end
          2: begin
            if (!(!mapDirty && !mapWp && vp == nextP3 && vp < mapped &&
                  int'(mapRpage) == expRp[vp] && p2Tot == V)) vR6++;
            if (vp > 0 && sNext[vp-1] != WORDS) vR7++;
            nextP3++;
          end
          default: vR6++;
        endcase
        mRp[vp] = int'(mapRpage);
        mD[vp]  = mapDirty;
        mW[vp]  = mapWp;
        wCnt[vp]++;
        busyCnt = 3;
      end
      if (flushReq) begin
        vp = int'(flushAddr) >> OFS_W;
        ln = (int'(flushAddr) >> LINE_W) & (LINES - 1);
        if (!(p1Tot == V && wCnt[vp] == 1 && ln == fNext[vp] &&
              (int'(flushAddr) % (1 << LINE_W)) == 0)) vR5++;
        fNext[vp]++;
        fTot++;
      end
      if (storeReq) begin
        vp = int'(storeAddr) >> OFS_W;
        of = int'(storeAddr) % WORDS;
        if (!(wCnt[vp] == 3 && of == sNext[vp] && storeData == 0 && vp == nextP3 - 1)) vR7++;
        sNext[vp]++;
        sTot++;
      end
      if (faultClear) begin
        fcCnt++;
        if (sTot != mapped * WORDS || mapBusy) vR9++;
      end
      if (ctrlLoad) begin
        clCnt++;
        if (fcCnt != 1 || ctrlValue != 2'b01) vR9++;
      end
      if (done && clCnt != 1) vR9++;
    end
  end

  task automatic runScenario(input logic [1:0] sel, input logic [3:0] mask,
                             input logic [1:0] chip, input bit stallOn, input string name);
    int ppm;
    int cnt;
    int r;
    int v;
    int bad;
    int reqAtEnd;
    @(negedge clk);
    rst = 1'b1;
    stall = stallOn;
    sizeSel = sel;
    modMask = mask;
    chipSize = chip;
    V = sel[1] ? 1024 : (sel[0] ? 256 : 64);
    ppm = 2 << (2 * int'(chip));
    cnt = 0;
    for (int m = 0; m < 4; m++) if (mask[m]) cnt++;
    for (int i = 0; i < NPG; i++) begin
      mRp[i] = -1; mD[i] = 0; mW[i] = 0; wCnt[i] = 0;
      fNext[i] = 0; sNext[i] = 0; expRp[i] = -1;
    end
    r = 0;
    v = 0;
    for (int m = 0; m < 4; m++) begin
      if (mask[m]) begin
        for (int p = 0; p < ppm; p++) begin
          if (v < V) begin
            expRp[v] = r + p;
            v++;
          end
        end
      end
      r += ppm;
    end
    mapped = v;
    p1Tot = 0; p2Tot = 0; nextP3 = 0; fTot = 0; sTot = 0; reqTot = 0; mwTot = 0;
    fcCnt = 0; clCnt = 0; vR4 = 0; vR5 = 0; vR6 = 0; vR7 = 0; vR9 = 0; vR10 = 0;
    repeat (3) @(negedge clk);
    #2;
    check(!mapWrite && !flushReq && !storeReq && !done && !noStorage && !faultClear && !ctrlLoad,
          "R11", int'(done) + int'(noStorage) + int'(mapWrite), 0, {name, " outputs idle in reset"});
    check(virtBanks == 0 && realPages == 0, "R11", int'(virtBanks) + int'(realPages), 0,
          {name, " sizes zero in reset"});
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 60000 && !(done || noStorage); i++) @(negedge clk);
    repeat (20) @(negedge clk);
    #2;
    if (mask == 4'b0000) begin
      check(noStorage && !done, "R3", int'(noStorage), 1, {name, " noStorage set, done low"});
      check(reqTot == 0, "R3", reqTot, 0, {name, " no requests"});
      check(realPages == 0, "R3", int'(realPages), 0, {name, " realPages"});
      reqAtEnd = reqTot;
      repeat (10) @(negedge clk);
      #2;
      check(noStorage && reqTot == reqAtEnd, "R3", reqTot, reqAtEnd, {name, " stays stopped"});
    end else begin
      check(int'(virtBanks) == V, "R1", int'(virtBanks), V, {name, " virtBanks"});
      check(int'(realPages) == ppm * cnt, "R2", int'(realPages), ppm * cnt, {name, " realPages"});
      check(p1Tot == V && vR4 == 0, "R4", vR4, 0, {name, " identity pass"});
      check(fTot == V * LINES && p2Tot == V && vR5 == 0, "R5", fTot, V * LINES, {name, " flush and vacate pass"});
      check(nextP3 == mapped && vR6 == 0, "R6", nextP3, mapped, {name, " compacted mapping"});
      check(sTot == mapped * WORDS && vR7 == 0, "R7", sTot, mapped * WORDS, {name, " page zeroing"});
      bad = 0;
      for (int i = 0; i < V; i++) begin
        if (i < mapped) begin
          if (mRp[i] != expRp[i] || mD[i] || mW[i]) bad++;
        end else begin
          if (mRp[i] != 0 || !mD[i] || !mW[i]) bad++;
        end
      end
      check(bad == 0 && mwTot == 2 * V + mapped, "R8", mwTot, 2 * V + mapped, {name, " final map"});
      check(done && fcCnt == 1 && clCnt == 1 && vR9 == 0, "R9", fcCnt * 10 + clCnt, 11, {name, " completion"});
      check(vR10 == 0, "R10", vR10, 0, {name, " no request while busy"});
    end
  endtask

  initial begin
    runScenario(2'b00, 4'b1111, 2'd0, 1'b0, "small_all");
    runScenario(2'b01, 4'b1010, 2'd1, 1'b1, "mid_gaps_stall");
    runScenario(2'b11, 4'b0100, 2'd3, 1'b0, "large_one_module");
    runScenario(2'b00, 4'b1101, 2'd2, 1'b0, "virtual_exhaust");
    runScenario(2'b10, 4'b0000, 2'd1, 1'b0, "no_storage");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule